// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation converter. A request to convert comes in on an active-low select and an active-low write strobe. The request is caught by an edge-independent latch and passed through a synchroniser into the conversion clock domain. A wide request keeps the search cleared. The search starts a few clocks after the request is withdrawn. It then walks a single marker bit from the most significant position down to bit zero. Each bit trial lasts a fixed number of clocks. During a trial the block drives a trial code to an external ladder and comparator model, and reads back one comparator bit.

When the last trial ends, the finished word is loaded into the output register and a one-clock transfer pulse is issued. One clock later an active-low completion flag drops. A fresh request at any time aborts the search in progress and raises the flag again. If the completion flag is wired back to the write input and the select is tied low, the block converts continuously. It still needs one external write after reset before the first conversion.

Top module: `sar_seq_top`

## Requirements
- R1: A start request is taken when `cs_n` and `wr_n` are both low. The request is latched, so a low pulse shorter than one clock period that falls between two rising edges still starts a conversion.
- R2: While `cs_n` and `wr_n` stay low, `trial_code` reads 0, `xfer` stays low and no trial is made. This holds for a request of any length.
- R3: After the request is withdrawn (either input goes high), the first trial code appears between 1 and 8 clock periods later.
- R4: The first trial code has only the most significant bit set (0x200 at 10 bits). Each trial keeps one bit position for 8 clocks. From the first trial code to the `xfer` pulse takes 80 clocks.
- R5: `cmp_below` = 1 means the input is below the current trial code, and the bit under trial is then cleared at the end of the trial. The result for an input difference v is v clamped to 0..1023. A full-scale input gives 0x3FF, and a negative or zero difference gives 0.
- R6: A new start request during a search aborts that search. The aborted search produces no `xfer`, and the next completed conversion reflects only the new search.
- R7: `xfer` is high for exactly one clock, in the same cycle in which `result` takes the new word. `eoc_n` falls in the following cycle. `result` does not change in any other cycle.
- R8: `eoc_n` returns high while a start request is held. With `cs_n` = 0 and `wr_n` driven by `eoc_n`, conversions repeat without further stimulus. After reset, no conversion starts until a write arrives.
- R9: A synchronous active-high `rst` clears `result` and `trial_code` to 0, drives `xfer` low and drives `eoc_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Start strobe, active low |
| cmp_below | input | 1 | Comparator: input is below the trial code |
| trial_code | output | DATA_W | Code under test, to the ladder model |
| result | output | DATA_W | Last completed conversion word |
| xfer | output | 1 | One-clock pulse when `result` is loaded |
| eoc_n | output | 1 | Completion flag, active low |

## Verification
The bench uses the default parameters: 10 data bits, 8 clocks per trial and a two-stage synchroniser. With these values a full 80-clock search finishes in under a hundred cycles, so many conversions fit in one run. Those include aborted searches, held strobes, a sub-clock pulse and several free-running loops through the `eoc_n` to `wr_n` feedback. A behavioural model that uses integers and a queue follows the latch and synchroniser delay. It predicts `trial_code`, `result`, `xfer` and `eoc_n` on every clock, and the directed checks measure the start latency and the trial length.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_SEARCH = 2'd2
  } seq_state_t;

  // total clocks of one search, used for sizing and documentation
  function automatic int unsigned search_clocks(input int unsigned bits, input int unsigned per_trial);
    return bits * per_trial;
  endfunction
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic wr_n,
  output logic held
);
  logic req_raw;
  logic req_latch;
  logic [SYNC_STAGES-1:0] chain;

  assign req_raw = ~cs_n & ~wr_n;

  // set without a clock edge so a narrow pulse is kept; cleared once seen synchronised and withdrawn
  always_ff @(posedge clk or posedge req_raw) begin
    if (req_raw)              req_latch <= 1'b1;
    else if (rst)             req_latch <= 1'b0;
    else if (chain[SYNC_STAGES-1]) req_latch <= 1'b0;
  end

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= req_latch;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign held = chain[SYNC_STAGES-1];
endmodule

// File: rtl/sar_search_core.sv
module sar_search_core
  import sar_seq_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int TRIAL_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              held,
  input  logic              below,
  output logic [DATA_W-1:0] trial_code,
  output logic [DATA_W-1:0] marker,
  output logic              busy,
  output logic              finish,
  output logic [DATA_W-1:0] word
);
  localparam int PH_W = (TRIAL_CLKS > 1) ? $clog2(TRIAL_CLKS) : 1;
  localparam logic [DATA_W-1:0] TOP_MARK = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TRIAL_CLKS - 1);

  seq_state_t        state;
  logic [DATA_W-1:0] sar;
  logic [PH_W-1:0]   phase;
  logic              trial_end;

  // decide the bit under test and place the next marker bit
  function automatic logic [DATA_W-1:0] settle_bit(
    input logic [DATA_W-1:0] code,
    input logic [DATA_W-1:0] mark,
    input logic              lower
  );
    logic [DATA_W-1:0] c;
    c = lower ? (code & ~mark) : code;
    return c | (mark >> 1);
  endfunction

  assign busy       = (state == ST_SEARCH);
  assign trial_end  = busy && (phase == PH_LAST);
  assign finish     = trial_end && marker[0];
  assign word       = settle_bit(sar, marker, below);
  assign trial_code = sar;

  always_ff @(posedge clk) begin
    if (rst || held) begin
      state  <= rst ? ST_IDLE : ST_ARMED;
      sar    <= '0;
      marker <= '0;
      phase  <= '0;
    end else begin
      case (state)
        ST_ARMED: begin
          state  <= ST_SEARCH;
          sar    <= TOP_MARK;
          marker <= TOP_MARK;
          phase  <= '0;
        end
        ST_SEARCH: begin
          if (trial_end) begin
            sar    <= word;
            marker <= marker >> 1;
            phase  <= '0;
            if (marker[0]) state <= ST_IDLE;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              held,
  input  logic              finish,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result,
  output logic              xfer,
  output logic              eoc_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      xfer   <= 1'b0;
      eoc_n  <= 1'b1;
    end else begin
      xfer <= finish && !held;
      if (finish && !held) result <= word;
      if (held)      eoc_n <= 1'b1;
      else if (xfer) eoc_n <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int DATA_W      = 10,
  parameter int TRIAL_CLKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              cmp_below,
  output logic [DATA_W-1:0] trial_code,
  output logic [DATA_W-1:0] result,
  output logic              xfer,
  output logic              eoc_n
);
  logic              held;
  logic              busy;
  logic              finish;
  logic [DATA_W-1:0] marker;
  logic [DATA_W-1:0] word;

  sar_start_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .held(held)
  );

  sar_search_core #(.DATA_W(DATA_W), .TRIAL_CLKS(TRIAL_CLKS)) core_i (
    .clk(clk), .rst(rst), .held(held), .below(cmp_below),
    .trial_code(trial_code), .marker(marker), .busy(busy),
    .finish(finish), .word(word)
  );

  sar_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .held(held), .finish(finish), .word(word),
    .result(result), .xfer(xfer), .eoc_n(eoc_n)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              held,
  input logic              busy,
  input logic [DATA_W-1:0] marker,
  input logic [DATA_W-1:0] trial_code,
  input logic [DATA_W-1:0] result,
  input logic              xfer,
  input logic              eoc_n
);
  // R2
  held_clears_trial_chk: assert property (@(posedge clk) disable iff (rst)
    held |=> (trial_code == '0));

  // R6
  restart_aborts_chk: assert property (@(posedge clk) disable iff (rst)
    (held && busy) |=> !busy);

  // R4
  one_marker_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(marker));

  // R7
  xfer_single_chk: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);

  // R7
  flag_follows_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !held) |=> !eoc_n);

  // R7
  result_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer |-> $stable(result));

  // R8
  flag_release_chk: assert property (@(posedge clk) disable iff (rst)
    held |=> eoc_n);
endmodule

bind sar_seq_top sar_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .held(held), .busy(busy), .marker(marker),
  .trial_code(trial_code), .result(result), .xfer(xfer), .eoc_n(eoc_n)
);

// File: tb/sar_seq_top_tb.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_drv = 1'b1;
  logic wr_drv = 1'b1;
  logic fr = 1'b0;
  int   vdiff = 0;
  bit   pulse_flag = 1'b0;

  logic [W-1:0] trial_code, result;
  logic xfer, eoc_n;
  wire cs_n = fr ? 1'b0 : cs_drv;
  wire wr_n = fr ? eoc_n : wr_drv;
  wire cmp_below = (vdiff < int'(trial_code));

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  sar_seq_top dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .cmp_below(cmp_below),
    .trial_code(trial_code), .result(result), .xfer(xfer), .eoc_n(eoc_n)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  bit m_lat = 0, m_arm = 0, m_busy = 0, m_xfer = 0, m_eoc = 1;
  int m_bit = 0, m_ph = 0, m_sar = 0, m_res = 0;
  bit sync_q[$] = '{1'b0, 1'b0};

  always @(posedge clk) begin
    bit req, lat_eff, held_o, xfer_o;
    req = ((fr ? 1'b0 : cs_drv) == 1'b0) && ((fr ? m_eoc : wr_drv) == 1'b0);
    held_o = sync_q[1];
    lat_eff = m_lat | req | pulse_flag;
    pulse_flag = 1'b0;
    if (rst) begin
      m_lat = req; sync_q = '{1'b0, 1'b0};
      m_arm = 0; m_busy = 0; m_bit = 0; m_ph = 0; m_sar = 0; m_res = 0;
      m_xfer = 0; m_eoc = 1;
    end else begin
      sync_q = '{lat_eff, sync_q[0]};
      m_lat = req ? 1'b1 : (held_o ? 1'b0 : lat_eff);
      xfer_o = m_xfer;
      m_xfer = 0;
      if (held_o) begin
        m_busy = 0; m_arm = 1; m_sar = 0; m_ph = 0; m_eoc = 1;
      end else begin
        if (xfer_o) m_eoc = 0;
        if (m_arm) begin
          m_arm = 0; m_busy = 1; m_bit = W-1; m_sar = 1 << (W-1); m_ph = 0;
        end else if (m_busy) begin
          if (m_ph == 7) begin
            if (vdiff < m_sar) m_sar -= (1 << m_bit);
            if (m_bit == 0) begin
              m_busy = 0; m_res = m_sar; m_xfer = 1;
            end else begin
              m_bit--; m_sar += (1 << m_bit);
            end
            m_ph = 0;
          end else m_ph++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(int'(trial_code) == m_sar, "R4 trial_code vs model", int'(trial_code), m_sar);
      chk(int'(result) == m_res, "R5 result vs model", int'(result), m_res);
      chk(xfer == m_xfer, "R7 xfer vs model", int'(xfer), int'(m_xfer));
      chk(eoc_n == m_eoc, "R8 eoc_n vs model", int'(eoc_n), int'(m_eoc));
    end
  end

  function automatic int clamp(input int v);
    return (v < 0) ? 0 : ((v > 1023) ? 1023 : v);
  endfunction

  task automatic start_pulse(input int width);
    @(negedge clk); cs_drv = 1'b0; wr_drv = 1'b0;
    repeat (width) @(negedge clk);
    wr_drv = 1'b1; cs_drv = 1'b1;
  endtask

  task automatic wait_xfer(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!xfer && n < 400);
  endtask

  task automatic convert(input int v, input string req);
    int n;
    vdiff = v;
    start_pulse(2);
    wait_xfer(n);
    chk(xfer == 1'b1, req, int'(xfer), 1);
    chk(int'(result) == clamp(v), req, int'(result), clamp(v));
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, xf;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    // R9 reset state
    chk(result == '0 && trial_code == '0, "R9 reset clears codes", int'(result), 0);
    chk(xfer == 1'b0 && eoc_n == 1'b1, "R9 reset flags", int'(eoc_n), 1);
    @(negedge clk); rst = 1'b0;

    // R8 no start without a write
    xf = 0;
    repeat (100) begin @(negedge clk); if (xfer) xf++; end
    chk(xf == 0 && eoc_n == 1'b1, "R8 idle after reset", xf, 0);

    // R5 data patterns
    convert(677, "R5 mid code");
    convert(5000, "R5 full scale");
    convert(1023, "R5 exact full scale");
    convert(-5, "R5 negative difference");
    convert(0, "R5 zero");
    convert(1, "R5 one lsb");

    // R3 latency and R4 search length
    vdiff = 300;
    start_pulse(3);
    n = 0;
    do begin @(negedge clk); n++; end while (trial_code != 10'h200 && n < 20);
    chk(n >= 1 && n <= 8, "R3 start latency", n, 4);
    chk(trial_code == 10'h200, "R4 msb first", int'(trial_code), 512);
    wait_xfer(n);
    chk(n == 80, "R4 search length", n, 80);
    chk(eoc_n == 1'b1, "R7 flag still high with xfer", int'(eoc_n), 1);
    @(negedge clk);
    chk(xfer == 1'b0 && eoc_n == 1'b0, "R7 flag falls after xfer", int'(eoc_n), 0);

    // R2 wide strobe holds
    @(negedge clk); cs_drv = 1'b0; wr_drv = 1'b0;
    repeat (4) @(negedge clk);
    xf = 0;
    repeat (50) begin
      @(negedge clk);
      if (trial_code != '0 || xfer) xf++;
    end
    chk(xf == 0, "R2 held strobe blocks search", xf, 0);
    chk(eoc_n == 1'b1, "R8 flag high while held", int'(eoc_n), 1);
    wr_drv = 1'b1; cs_drv = 1'b1;
    wait_xfer(n);
    chk(int'(result) == 300, "R2 converts after release", int'(result), 300);

    // R1 sub-clock pulse
    vdiff = 451;
    @(negedge clk);
    #0.5 cs_drv = 1'b0; wr_drv = 1'b0; pulse_flag = 1'b1;
    #1.0 wr_drv = 1'b1; cs_drv = 1'b1;
    wait_xfer(n);
    chk(xfer == 1'b1 && int'(result) == 451, "R1 narrow pulse starts", int'(result), 451);

    // R6 abort
    vdiff = 100;
    start_pulse(2);
    xf = 0;
    repeat (30) begin @(negedge clk); if (xfer) xf++; end
    vdiff = 900;
    start_pulse(2);
    wait_xfer(n);
    chk(xf == 0, "R6 no xfer from aborted search", xf, 0);
    chk(int'(result) == 900, "R6 restart result", int'(result), 900);

    // R8 free running
    vdiff = 222;
    repeat (2) @(negedge clk);
    fr = 1'b1;
    xf = 0;
    repeat (400) begin @(negedge clk); if (xfer) xf++; end
    chk(xf >= 3, "R8 free running repeats", xf, 4);
    chk(int'(result) == 222, "R8 free running result", int'(result), 222);
    fr = 1'b0;
    repeat (120) @(negedge clk);

    // R9 reset during search
    vdiff = 700;
    start_pulse(2);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(result == '0 && trial_code == '0 && eoc_n == 1'b1, "R9 reset mid search", int'(result), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule